// File: doc/BRIEF.md
# UART Receive FIFO with Idle Timeout

This block buffers received characters on the receive side of a serial port. A bit-level receiver hands over one deserialized byte per `rx_valid_i` pulse and the block queues it in a byte FIFO. Software drains the queue one byte per read strobe on the receive holding register. It can also observe the fill count, a full flag and a sticky overrun flag.

Two request sources serve the interrupt logic. `rx_req_o` stays high while the fill level is at or above a trigger threshold. The threshold is programmed as an eighth-step ratio of the FIFO depth. A status flag, the idle timeout, rises when received data has gone unread while the line has been quiet for a programmed number of whole character frames. A frame-time pulse from the baud logic, `frame_tick_i`, paces the timeout. Software clears the flag with a write-one strobe.

With FIFO mode off, the queue acts as a single holding register. Configuration arrives on plain ports, and software accesses arrive as single-cycle strobes.

Top module: `uart_rx_fifo_to`

## Requirements
- R1: Bytes are read back in arrival order. `fifo_stat_o[7:0]` holds the stored byte count, and `fifo_stat_o[8]` is high when the count equals the capacity (DEPTH in FIFO mode). `rx_stat_o[0]` is high whenever the count is non-zero.
- R2: A read strobe while the FIFO is empty returns 0 on `rhr_data_o` and leaves the count at 0.
- R3: A byte arriving at a full FIFO, with no read in the same cycle, is dropped and the stored data is unchanged. The drop sets `fifo_stat_o[9]`, which stays set until an `err_rd_i` strobe clears it.
- R4: `rx_req_o` is high exactly when count >= (trig_lvl_i+1)*DEPTH/8 in FIFO mode. With DEPTH=16, trigger level 7 needs 16 bytes, level 1 needs 4 and level 0 needs 2.
- R5: With `to_en_i` set, the timeout flag `rx_stat_o[3]` rises after 8*(to_frames_i+1) `frame_tick_i` pulses that follow the last received byte. It fires once for each arrival of data.
- R6: Each received byte and each holding-register read restarts the frame count of the timeout.
- R7: With `to_on_empty_i` low, the timeout does not run while the FIFO is empty. With it high, the timeout runs on an empty FIFO once data has arrived.
- R8: A `to_clr_i` strobe clears `rx_stat_o[3]`.
- R9: A `fifo_flush_i` strobe empties the FIFO, drops the request and restarts the timeout.
- R10: With `fifo_en_i` low, the block holds one byte and the request threshold is 1. A second byte overruns.
- R11: With `to_en_i` low, no timeout is raised.
- R12: After reset, the count, the flags, the request and `rhr_data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte strobe from the shifter |
| rx_data_i | input | 8 | Received byte |
| frame_tick_i | input | 1 | One pulse per character frame time |
| fifo_en_i | input | 1 | FIFO mode; low gives a one-byte holding register |
| fifo_flush_i | input | 1 | Empties the receive FIFO |
| trig_lvl_i | input | 3 | Request threshold in eighths of depth, minus one |
| to_en_i | input | 1 | Idle timeout enable |
| to_frames_i | input | 4 | Timeout N, giving 8*(N+1) frames |
| to_on_empty_i | input | 1 | Lets the timeout run on an empty FIFO |
| rhr_rd_i | input | 1 | Holding-register read strobe |
| err_rd_i | input | 1 | Error-status read strobe, clears overrun |
| to_clr_i | input | 1 | Write-one-to-clear strobe for the timeout flag |
| rhr_data_o | output | 8 | Oldest byte, or 0 when empty |
| rx_stat_o | output | 4 | Bit 3 timeout, bit 0 data ready |
| fifo_stat_o | output | 10 | Bit 9 overrun, bit 8 full, bits 7:0 count |
| rx_req_o | output | 1 | Fill level at or above the trigger |

## Verification
The bench fills the queue to capacity and then pushes one more byte. A design that wrapped the write pointer would corrupt the oldest byte, and one that lacked the sticky flag would hide the loss. The timeout is tested one tick short of and exactly at 8*(N+1) frames, after restarts caused by both arrivals and reads. This catches off-by-one counters and timers that ignore reads. Empty-FIFO behaviour is tested in both settings of the empty control: a timer stuck running would fire on a drained queue, and a read of an empty queue that moved the count would wrap it. Trigger levels are probed one byte below and at the threshold, in FIFO mode and in single-byte mode.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int unsigned STAT_RDY_BIT  = 0;
  localparam int unsigned STAT_TO_BIT   = 3;
  localparam int unsigned FST_FULL_BIT  = 8;
  localparam int unsigned FST_ERR_BIT   = 9;
  localparam int unsigned CNT_FIELD_W   = 8;

  typedef struct packed {
    logic       en;
    logic       on_empty;
    logic [3:0] frames;
  } to_cfg_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          cap_one_i,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  input  logic          rd_i,
  output logic [7:0]    rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          drop_o
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cap;
  logic          do_rd, do_wr;

  assign cap    = cap_one_i ? CW'(1) : CW'(DEPTH);
  assign full_o = (cnt >= cap);
  assign do_rd  = rd_i && (cnt != '0);
  // a concurrent read frees the slot, so a full queue still takes the byte
  assign do_wr  = wr_i && (!full_o || do_rd);
  assign drop_o = wr_i && !do_wr;

  always_ff @(posedge clk_i) begin
    if (do_wr) mem[wp] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush_i) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      if (do_wr && !do_rd)      cnt <= cnt + 1'b1;
      else if (do_rd && !do_wr) cnt <= cnt - 1'b1;
    end
  end

  assign rdata_o = (cnt != '0) ? mem[rp] : 8'h00;
  assign count_o = cnt;

  p_no_overflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));
  p_empty_read_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && cnt == '0 && !wr_i) |=> cnt == '0);
  p_drop_keeps_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_o && !flush_i) |=> $stable(cnt));
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH) + 1,
  localparam int unsigned STEP = DEPTH / 8
) (
  input  logic [CW-1:0] count_i,
  input  logic [2:0]    trig_i,
  input  logic          fifo_en_i,
  output logic          req_o
);
  logic [CW-1:0] thr;

  always_comb begin
    if (fifo_en_i) thr = CW'((int'(trig_i) + 1) * STEP);
    else           thr = CW'(1);
  end

  assign req_o = (count_i >= thr);

  always_comb begin
    if (req_o) p_req_has_data_r4: assert (count_i != '0);
  end
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer
  import uart_rxq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  to_cfg_t cfg_i,
  input  logic    flush_i,
  input  logic    empty_i,
  input  logic    rx_i,
  input  logic    rd_i,
  input  logic    tick_i,
  input  logic    clr_i,
  output logic    flag_o
);
  logic [6:0] frm, limit_m1;
  logic       armed, run, restart, fire;

  assign limit_m1 = {cfg_i.frames, 3'b111};
  assign run      = cfg_i.en && armed && (!empty_i || cfg_i.on_empty);
  assign restart  = rx_i || rd_i || !run;
  assign fire     = !flush_i && !restart && tick_i && (frm == limit_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm   <= '0;
      armed <= 1'b0;
    end else if (flush_i) begin
      frm   <= '0;
      armed <= 1'b0;
    end else if (restart) begin
      frm <= '0;
      if (rx_i) armed <= 1'b1;
    end else if (tick_i) begin
      if (fire) begin
        frm   <= '0;
        armed <= 1'b0;
      end else begin
        frm <= frm + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (fire)   flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  p_fire_enabled_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(cfg_i.en));
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !tick_i) |=> !flag_o);
  p_arrival_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_i && !clr_i) |=> flag_o == $past(flag_o));
endmodule

// File: rtl/uart_rx_fifo_to.sv
module uart_rx_fifo_to
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       frame_tick_i,
  input  logic       fifo_en_i,
  input  logic       fifo_flush_i,
  input  logic [2:0] trig_lvl_i,
  input  logic       to_en_i,
  input  logic [3:0] to_frames_i,
  input  logic       to_on_empty_i,
  input  logic       rhr_rd_i,
  input  logic       err_rd_i,
  input  logic       to_clr_i,
  output logic [7:0] rhr_data_o,
  output logic [3:0] rx_stat_o,
  output logic [9:0] fifo_stat_o,
  output logic       rx_req_o
);
  localparam int unsigned CW = $clog2(DEPTH) + 1;

  logic [CW-1:0] cnt;
  logic          full, drop, ovr_err, to_flag;
  to_cfg_t       to_cfg;

  assign to_cfg = '{en: to_en_i, on_empty: to_on_empty_i, frames: to_frames_i};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (fifo_flush_i),
    .cap_one_i (!fifo_en_i),
    .wr_i      (rx_valid_i),
    .wdata_i   (rx_data_i),
    .rd_i      (rhr_rd_i),
    .rdata_o   (rhr_data_o),
    .count_o   (cnt),
    .full_o    (full),
    .drop_o    (drop)
  );

  rxq_level #(.DEPTH(DEPTH)) u_level (
    .count_i   (cnt),
    .trig_i    (trig_lvl_i),
    .fifo_en_i (fifo_en_i),
    .req_o     (rx_req_o)
  );

  rxq_idle_timer u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_i   (to_cfg),
    .flush_i (fifo_flush_i),
    .empty_i (cnt == '0),
    .rx_i    (rx_valid_i),
    .rd_i    (rhr_rd_i),
    .tick_i  (frame_tick_i),
    .clr_i   (to_clr_i),
    .flag_o  (to_flag)
  );

  // overrun is sticky; a new drop wins over a concurrent status read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ovr_err <= 1'b0;
    else if (drop)     ovr_err <= 1'b1;
    else if (err_rd_i) ovr_err <= 1'b0;
  end

  always_comb begin
    rx_stat_o                = '0;
    rx_stat_o[STAT_RDY_BIT]  = (cnt != '0);
    rx_stat_o[STAT_TO_BIT]   = to_flag;
    fifo_stat_o              = '0;
    fifo_stat_o[CNT_FIELD_W-1:0] = CNT_FIELD_W'(cnt);
    fifo_stat_o[FST_FULL_BIT] = full;
    fifo_stat_o[FST_ERR_BIT]  = ovr_err;
  end

  p_drop_flags_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> fifo_stat_o[FST_ERR_BIT]);
  p_flush_empties_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_flush_i |=> (fifo_stat_o[7:0] == 8'd0 && !rx_req_o));
endmodule

// File: tb/tb_uart_rx_fifo_to.sv
module tb_uart_rx_fifo_to;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       frame_tick_i = 1'b0;
  logic       fifo_en_i = 1'b1;
  logic       fifo_flush_i = 1'b0;
  logic [2:0] trig_lvl_i = 3'd7;
  logic       to_en_i = 1'b0;
  logic [3:0] to_frames_i = 4'd0;
  logic       to_on_empty_i = 1'b0;
  logic       rhr_rd_i = 1'b0;
  logic       err_rd_i = 1'b0;
  logic       to_clr_i = 1'b0;
  logic [7:0] rhr_data_o;
  logic [3:0] rx_stat_o;
  logic [9:0] fifo_stat_o;
  logic       rx_req_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  uart_rx_fifo_to dut (.*);

  // {op, byte, expected status}: op 0 push, 1 pop and compare, 2 compare fifo_stat_o
  localparam logic [19:0] VEC [12] = '{
    {2'd0, 8'h11, 10'h000}, {2'd0, 8'h22, 10'h000}, {2'd0, 8'h33, 10'h000},
    {2'd2, 8'h00, 10'h003}, {2'd1, 8'h11, 10'h000}, {2'd0, 8'h44, 10'h000},
    {2'd2, 8'h00, 10'h003}, {2'd1, 8'h22, 10'h000}, {2'd1, 8'h33, 10'h000},
    {2'd1, 8'h44, 10'h000}, {2'd2, 8'h00, 10'h000}, {2'd1, 8'h00, 10'h000}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk_i);
    rx_valid_i = 1'b1;
    rx_data_i  = d;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  task automatic pop(input logic [7:0] exp, input string req);
    @(negedge clk_i);
    chk(req, rhr_data_o, exp);
    rhr_rd_i = 1'b1;
    @(negedge clk_i);
    rhr_rd_i = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      frame_tick_i = 1'b1;
      @(negedge clk_i);
      frame_tick_i = 1'b0;
    end
  endtask

  task automatic strobe_flush();
    @(negedge clk_i); fifo_flush_i = 1'b1;
    @(negedge clk_i); fifo_flush_i = 1'b0;
  endtask

  task automatic strobe_clr();
    @(negedge clk_i); to_clr_i = 1'b1;
    @(negedge clk_i); to_clr_i = 1'b0;
  endtask

  task automatic strobe_err();
    @(negedge clk_i); err_rd_i = 1'b1;
    @(negedge clk_i); err_rd_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R12 reset state
    chk("R12 fifo_stat", fifo_stat_o, 0);
    chk("R12 rx_stat", rx_stat_o, 0);
    chk("R12 req", rx_req_o, 0);
    chk("R12 rhr_data", rhr_data_o, 0);

    // R1 ordering and count from the vector table; last entry is R2 empty read
    for (int i = 0; i < 12; i++) begin
      case (VEC[i][19:18])
        2'd0: push(VEC[i][17:10]);
        2'd1: pop(VEC[i][17:10], "R1 order");
        default: chk("R1 count", fifo_stat_o, int'(VEC[i][9:0]));
      endcase
    end
    chk("R2 count after empty read", fifo_stat_o, 0);
    chk("R1 ready low when empty", rx_stat_o[0], 0);

    // R1 fill to capacity, R4 threshold at level 7
    for (int i = 0; i < 15; i++) push(8'(i));
    chk("R4 level7 at 15", rx_req_o, 0);
    chk("R1 ready bit", rx_stat_o[0], 1);
    push(8'd15);
    chk("R4 level7 at 16", rx_req_o, 1);
    chk("R1 full", fifo_stat_o, 10'h110);
    // R3 overrun
    push(8'hEE);
    chk("R3 overrun flag", fifo_stat_o, 10'h310);
    strobe_err();
    chk("R3 flag cleared by status read", fifo_stat_o, 10'h110);
    for (int i = 0; i < 16; i++) pop(8'(i), "R3 data intact");
    chk("R3 dropped byte absent", fifo_stat_o, 0);

    // R4 lower trigger levels
    trig_lvl_i = 3'd1;
    for (int i = 0; i < 3; i++) push(8'hA0);
    chk("R4 level1 at 3", rx_req_o, 0);
    push(8'hA1);
    chk("R4 level1 at 4", rx_req_o, 1);
    trig_lvl_i = 3'd0;
    @(negedge clk_i);
    chk("R4 level0 at 4", rx_req_o, 1);
    // R9 flush
    strobe_flush();
    chk("R9 flush count", fifo_stat_o, 0);
    chk("R9 flush req", rx_req_o, 0);
    push(8'h01);
    chk("R4 level0 at 1", rx_req_o, 0);
    strobe_flush();

    // R10 single-byte mode
    fifo_en_i = 1'b0;
    push(8'h5C);
    chk("R10 req at 1", rx_req_o, 1);
    chk("R10 full at 1", fifo_stat_o, 10'h101);
    push(8'h5D);
    chk("R10 second byte overruns", fifo_stat_o, 10'h301);
    pop(8'h5C, "R10 held byte");
    pop(8'h00, "R10 empty after one");
    strobe_err();
    fifo_en_i = 1'b1;
    trig_lvl_i = 3'd7;

    // R5 timeout, N=0 -> 8 frames
    to_en_i = 1'b1;
    push(8'h5A);
    tick(7);
    chk("R5 no timeout at 7 frames", rx_stat_o[3], 0);
    tick(1);
    chk("R5 timeout at 8 frames", rx_stat_o[3], 1);
    strobe_clr();
    chk("R8 clear", rx_stat_o[3], 0);
    tick(8);
    chk("R5 fires once per arrival", rx_stat_o[3], 0);

    // R6 restart on read and on arrival
    push(8'h6B);
    tick(5);
    pop(8'h5A, "R6 data");
    tick(7);
    chk("R6 read restarts count", rx_stat_o[3], 0);
    tick(1);
    chk("R6 fires after read restart", rx_stat_o[3], 1);
    strobe_clr();
    push(8'h7C);
    tick(6);
    push(8'h7D);
    tick(7);
    chk("R6 arrival restarts count", rx_stat_o[3], 0);
    tick(1);
    chk("R6 fires after arrival restart", rx_stat_o[3], 1);
    strobe_clr();

    // R7 empty-FIFO control
    strobe_flush();
    push(8'h11);
    pop(8'h11, "R7 data");
    tick(8);
    chk("R7 no timeout on empty", rx_stat_o[3], 0);
    to_on_empty_i = 1'b1;
    push(8'h22);
    pop(8'h22, "R7 data");
    tick(8);
    chk("R7 timeout on empty when allowed", rx_stat_o[3], 1);
    strobe_clr();
    to_on_empty_i = 1'b0;

    // R11 disabled timeout, then N=1 -> 16 frames
    to_en_i = 1'b0;
    push(8'h33);
    tick(8);
    chk("R11 disabled", rx_stat_o[3], 0);
    to_en_i = 1'b1;
    to_frames_i = 4'd1;
    tick(15);
    chk("R5 N=1 at 15", rx_stat_o[3], 0);
    tick(1);
    chk("R5 N=1 at 16", rx_stat_o[3], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule